// File: doc/BRIEF.md
# Serial Receiver with Control and Status Byte

This block receives serial words and keeps them in a small queue for a host to read. It has two modes. In the asynchronous mode it watches an idle-high line for a start bit and then takes 8 or 9 data bits and a stop bit, sampling 16 times per bit. In the synchronous master mode it drives the serial clock itself and takes one data bit on each rising clock edge. In both modes the least significant bit arrives first. The `sync_mode` input selects the mode. The bit rate comes from `baud_div`: the internal tick fires once every `baud_div + 1` clock cycles. In the asynchronous mode a bit lasts 16 ticks. In the synchronous mode each clock phase lasts one tick.

A single byte-wide register holds the control bits and shows the status. The host writes it through `csr_wr`/`csr_wdata` and reads it at any time on `csr_rdata`. The control bits are: port enable, 9-bit select, single-shot receive and continuous receive. Framing error and ninth data bit belong to the word at the head of the queue. Overrun is a sticky flag. A pulse on `data_rd` removes the head word, so the next word and its flags appear.

Top module: `serrx_top`

## Requirements
- R1: After reset, `csr_rdata[7:1]` is 0, `data_valid` is 0 and `sclk_out` is low. `csr_rdata[3]` always reads 0.
- R2: With `sync_mode`=0, port enable (bit 7) and continuous receive (bit 4) set, an idle-high frame is received and shown on `data_out` with `data_valid`=1. The frame is one low start bit, the data bits LSB first, and one stop bit. Words are delivered in arrival order.
- R3: With bit 6 set, a frame carries 9 data bits. The ninth bit of the head word reads on `csr_rdata[0]`. In 8-bit frames that bit reads 0.
- R4: A stop bit sampled low marks its word with a framing error, which reads on `csr_rdata[2]` while that word is at the head. The flag follows the head word on each read.
- R5: A low pulse shorter than half a bit is treated as noise, and no word is produced. A start bit counts only if the line is still low at mid-bit. Each bit value is the majority of three samples.
- R6: With port enable 0, nothing is received and `sclk_out` stays low.
- R7: In the asynchronous mode, single-shot receive (bit 5) has no effect: with only bits 7 and 5 set, no word is received.
- R8: In the synchronous mode with bits 7 and 5 set, exactly one word is clocked in on rising `sclk_out` edges. Bit 5 then clears by itself and `sclk_out` returns low and stays low.
- R9: In the synchronous mode, continuous receive overrides single-shot: words are clocked in back to back and bit 5 is not cleared.
- R10: The queue holds two words. A word that completes while the queue is full sets overrun (`csr_rdata[1]`) and is discarded. No further reception takes place while overrun is set.
- R11: Overrun stays set through any write that keeps bit 4 at 1. It is cleared by a write with bit 4 = 0.
- R12: A one-cycle `data_rd` while `data_valid` is 1 removes the head word. Without a read, `data_valid` never falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_mode | input | 1 | 1 = synchronous master mode, 0 = asynchronous mode |
| baud_div | input | DIV_W | Tick period minus one, in clock cycles |
| rx_in | input | 1 | Serial data line |
| sclk_out | output | 1 | Serial clock driven in synchronous master mode |
| csr_wr | input | 1 | Write strobe for control bits [7:4] |
| csr_wdata | input | 8 | Write data |
| csr_rdata | output | 8 | Control and status byte |
| data_rd | input | 1 | Remove the head word from the queue |
| data_out | output | 8 | Head word data |
| data_valid | output | 1 | Queue is not empty |

## Verification
A wrong sample counter or bit counter shows up within the same frame. The word lands on `data_out` shifted by one bit position, or with a false framing flag, one cycle after the stop decision. A fault in the queue pointers shows up on the next read, as a word that repeats or is skipped in the scoreboard order. A fault in the sticky flags shows up at once in `csr_rdata`. For example, reception resumes while overrun is set, or a clock edge appears after a single-shot word, and that is visible at the ports within a few ticks.

// File: rtl/serrx_pkg.sv
package serrx_pkg;
    typedef struct packed {
        logic       ferr;
        logic       b9;
        logic [7:0] data;
    } rx_word_t;

    typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rx_st_e;
endpackage

// File: rtl/serrx_tick.sv
module serrx_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == div) begin
            cnt_d = '0;
            tick  = 1'b1;
        end else begin
            cnt_d = cnt_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/serrx_fifo.sv
module serrx_fifo
    import serrx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  rx_word_t wdata,
    input  logic     pop,
    output logic     full,
    output logic     valid,
    output rx_word_t head
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        rx_word_t [DEPTH-1:0] mem;
        logic [PW-1:0]        rp;
        logic [PW-1:0]        wp;
        logic [CW-1:0]        cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic do_push, do_pop;

    function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full  = (q.cnt == CW'(DEPTH));
    assign valid = (q.cnt != '0);
    assign head  = q.mem[q.rp];

    always_comb begin
        d       = q;
        do_push = push && !full;
        do_pop  = pop && valid;
        if (do_push) begin
            d.mem[q.wp] = wdata;
            d.wp        = adv(q.wp);
        end
        if (do_pop) d.rp = adv(q.rp);
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + CW'(1);
            2'b01:   d.cnt = q.cnt - CW'(1);
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/serrx_frame.sv
module serrx_frame
    import serrx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     rx,
    input  logic     sync_mode,
    input  logic     nine,
    input  logic     async_en,
    input  logic     sync_en,
    output logic     done,
    output rx_word_t word,
    output logic     sclk
);
    localparam int OW   = $clog2(OVS);
    localparam int HALF = OVS / 2;

    typedef struct packed {
        rx_st_e        st;
        logic [OW-1:0] cnt;
        logic [3:0]    bitn;
        logic [8:0]    sh;
        logic [1:0]    smp;
        logic          sclk;
    } eng_t;

    eng_t q, d;
    logic       last, maj, rbit;
    logic [8:0] shin;

    function automatic rx_word_t pack_word(input logic [8:0] s, input logic nn,
                                           input logic f);
        rx_word_t w;
        w.ferr = f;
        w.b9   = nn ? s[8] : 1'b0;
        w.data = nn ? s[7:0] : s[8:1];
        return w;
    endfunction

    assign sclk = q.sclk;

    always_comb begin
        d    = q;
        done = 1'b0;
        word = '0;
        last = (q.bitn == (nine ? 4'd8 : 4'd7));
        maj  = (q.smp[1] & q.smp[0]) | (q.smp[1] & rx) | (q.smp[0] & rx);
        rbit = sync_mode ? rx : maj;
        shin = {rbit, q.sh[8:1]};
        if (tick) d.smp = {q.smp[0], rx};
        if (sync_mode) begin
            d.st  = ST_IDLE;
            d.cnt = '0;
            if (!sync_en) begin
                d.bitn = '0;
                d.sclk = 1'b0;
            end else if (tick) begin
                d.sclk = !q.sclk;
                if (!q.sclk) begin
                    d.sh = shin;
                    if (last) begin
                        done   = 1'b1;
                        word   = pack_word(shin, nine, 1'b0);
                        d.bitn = '0;
                    end else begin
                        d.bitn = q.bitn + 4'd1;
                    end
                end
            end
        end else begin
            d.sclk = 1'b0;
            if (!async_en) begin
                d.st   = ST_IDLE;
                d.cnt  = '0;
                d.bitn = '0;
            end else if (tick) begin
                d.cnt = q.cnt + OW'(1);
                case (q.st)
                    ST_IDLE: begin
                        d.cnt = '0;
                        if (!rx) d.st = ST_START;
                    end
                    ST_START: begin
                        if (q.cnt == OW'(HALF - 1)) begin
                            d.cnt  = '0;
                            d.bitn = '0;
                            d.st   = rx ? ST_IDLE : ST_DATA;
                        end
                    end
                    ST_DATA: begin
                        if (q.cnt == OW'(OVS - 1)) begin
                            d.cnt = '0;
                            d.sh  = shin;
                            if (last) d.st = ST_STOP;
                            else      d.bitn = q.bitn + 4'd1;
                        end
                    end
                    default: begin
                        if (q.cnt == OW'(OVS - 1)) begin
                            done   = 1'b1;
                            word   = pack_word(q.sh, nine, !maj);
                            d.cnt  = '0;
                            d.bitn = '0;
                            d.st   = ST_IDLE;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_IDLE;
            q.smp <= 2'b11;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/serrx_top.sv
module serrx_top
    import serrx_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int DEPTH = 2,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_mode,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             rx_in,
    output logic             sclk_out,
    input  logic             csr_wr,
    input  logic [7:0]       csr_wdata,
    output logic [7:0]       csr_rdata,
    input  logic             data_rd,
    output logic [7:0]       data_out,
    output logic             data_valid
);
    typedef struct packed {
        logic spen;
        logic nine;
        logic sren;
        logic cren;
        logic oerr;
        logic s1;
        logic s2;
    } csr_t;

    csr_t     q, d;
    logic     tick, done, full, async_en, sync_en;
    rx_word_t word, head;

    assign async_en = q.spen && q.cren && !q.oerr;
    assign sync_en  = q.spen && (q.cren || q.sren) && !q.oerr;

    serrx_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(q.spen), .div(baud_div), .tick(tick)
    );

    serrx_frame #(.OVS(OVS)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx(q.s2), .sync_mode(sync_mode),
        .nine(q.nine), .async_en(async_en), .sync_en(sync_en),
        .done(done), .word(word), .sclk(sclk_out)
    );

    serrx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(done), .wdata(word), .pop(data_rd),
        .full(full), .valid(data_valid), .head(head)
    );

    always_comb begin
        d    = q;
        d.s1 = rx_in;
        d.s2 = q.s1;
        if (done && full) d.oerr = 1'b1;
        if (done && sync_mode && !q.cren) d.sren = 1'b0;
        if (csr_wr) begin
            d.spen = csr_wdata[7];
            d.nine = csr_wdata[6];
            d.sren = csr_wdata[5];
            d.cren = csr_wdata[4];
            if (!csr_wdata[4]) d.oerr = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{spen: 1'b0, nine: 1'b0, sren: 1'b0, cren: 1'b0,
                           oerr: 1'b0, s1: 1'b1, s2: 1'b1};
        else        q <= d;
    end

    assign csr_rdata = {q.spen, q.nine, q.sren, q.cren, 1'b0,
                        data_valid & head.ferr, q.oerr, head.b9};
    assign data_out  = head.data;
endmodule

// File: rtl/serrx_chk.sv
module serrx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sync_mode,
    input logic       sclk_out,
    input logic       csr_wr,
    input logic [7:0] csr_wdata,
    input logic [7:0] csr_rdata,
    input logic       data_rd,
    input logic [7:0] data_out,
    input logic       data_valid
);
    assert_noclk_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_rdata[7] |=> !sclk_out);

    assert_noclk_async_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_mode |=> !sclk_out);

    assert_oerr_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata[1] && !(csr_wr && !csr_wdata[4])) |=> csr_rdata[1]);

    assert_halt_on_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata[1] && data_valid && !data_rd) |=> (data_valid && $stable(data_out)));

    assert_no_loss_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && !data_rd) |=> data_valid);

    assert_single_autoclear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(csr_rdata[5]) && !$past(csr_wr)) |-> ($past(sync_mode) && !$past(csr_rdata[4])));
endmodule

bind serrx_top serrx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .sclk_out(sclk_out),
    .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .data_rd(data_rd), .data_out(data_out), .data_valid(data_valid)
);

// File: tb/sim_serrx_top.sv
module sim_serrx_top;
    localparam int CLK_P = 10;
    localparam int DIV   = 1;
    localparam int BITC  = 16 * (DIV + 1);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_mode = 1'b0;
    logic [7:0] baud_div = 8'(DIV);
    logic       rx_in = 1'b1;
    logic       sclk_out;
    logic       csr_wr = 1'b0;
    logic [7:0] csr_wdata = '0;
    logic [7:0] csr_rdata;
    logic       mon_rd = 1'b0, man_rd = 1'b0, auto_rd = 1'b0;
    logic       data_rd;
    logic [7:0] data_out;
    logic       data_valid;
    int         n_tests = 0, n_fail = 0;
    logic [9:0] exp_q[$];

    assign data_rd = mon_rd | man_rd;
    always #(CLK_P / 2) clk = ~clk;

    serrx_top u0 (
        .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .baud_div(baud_div),
        .rx_in(rx_in), .sclk_out(sclk_out), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .data_rd(data_rd), .data_out(data_out),
        .data_valid(data_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected {ferr, b9, data} and compares with the head word
    always @(negedge clk) begin
        if (mon_rd) mon_rd = 1'b0;
        else if (auto_rd && data_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected word", int'(data_out), 0);
            end else begin
                logic [9:0] e;
                e = exp_q.pop_front();
                chk({csr_rdata[2], csr_rdata[0], data_out} == e, "R2/R3/R4 word",
                    int'({csr_rdata[2], csr_rdata[0], data_out}), int'(e));
            end
            mon_rd = 1'b1;
        end
    end

    task automatic wr(input logic [7:0] v);
        csr_wdata = v;
        csr_wr    = 1'b1;
        @(posedge clk); #1;
        csr_wr    = 1'b0;
    endtask

    task automatic hold(input logic v);
        rx_in = v;
        repeat (BITC) @(posedge clk);
        #1;
    endtask

    task automatic uart_send(input logic [8:0] v, input bit nine, input logic stopv);
        hold(1'b0);
        for (int i = 0; i < (nine ? 9 : 8); i++) hold(v[i]);
        hold(stopv);
        hold(1'b1);
    endtask

    task automatic sync_bits(input logic [17:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge sclk_out); #1;
            if (i + 1 < n) rx_in = b[i+1];
        end
    endtask

    task automatic man_read();
        man_rd = 1'b1;
        @(posedge clk); #1;
        man_rd = 1'b0;
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(posedge clk);
        repeat (4) @(posedge clk); #1;
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        chk(csr_rdata[7:1] == 7'd0, "R1 status after reset", int'(csr_rdata), 0);
        chk(!data_valid, "R1 data_valid after reset", int'(data_valid), 0);
        chk(!sclk_out, "R1 sclk after reset", int'(sclk_out), 0);

        // R2 async 8-bit, R4 framing error on bad stop
        auto_rd = 1'b1;
        wr(8'h90);
        exp_q.push_back({2'b00, 8'hA5}); uart_send(9'h0A5, 0, 1'b1);
        exp_q.push_back({2'b00, 8'h3C}); uart_send(9'h03C, 0, 1'b1);
        exp_q.push_back({2'b10, 8'h5A}); uart_send(9'h05A, 0, 1'b0);
        exp_q.push_back({2'b00, 8'h81}); uart_send(9'h081, 0, 1'b1);
        drain("R2 async words delivered");
        chk(csr_rdata[3] == 1'b0, "R1 unused bit", int'(csr_rdata[3]), 0);

        // R3 nine-bit frames
        wr(8'hD0);
        exp_q.push_back({2'b01, 8'h33}); uart_send(9'h133, 1, 1'b1);
        exp_q.push_back({2'b00, 8'hC4}); uart_send(9'h0C4, 1, 1'b1);
        drain("R3 nine-bit words");
        wr(8'h90);

        // R5 short low pulse ignored
        rx_in = 1'b0; repeat (3) @(posedge clk); #1; rx_in = 1'b1;
        repeat (600) @(posedge clk); #1;
        chk(!data_valid, "R5 glitch ignored", int'(data_valid), 0);

        // R7 single-shot ignored in async mode
        wr(8'hA0);
        uart_send(9'h077, 0, 1'b1);
        chk(!data_valid, "R7 sren async no word", int'(data_valid), 0);
        chk(!sclk_out, "R7 no clock in async", int'(sclk_out), 0);

        // R6 port disabled
        wr(8'h10);
        uart_send(9'h0E7, 0, 1'b1);
        chk(!data_valid, "R6 disabled no word", int'(data_valid), 0);

        // R4 framing flag follows head, R12 read pops
        auto_rd = 1'b0;
        wr(8'h90);
        uart_send(9'h011, 0, 1'b0);
        uart_send(9'h022, 0, 1'b1);
        chk(csr_rdata[2] && data_out == 8'h11, "R4 head has ferr",
            int'({csr_rdata[2], data_out}), 'h111);
        man_read();
        chk(!csr_rdata[2] && data_out == 8'h22, "R4 ferr follows head R12",
            int'({csr_rdata[2], data_out}), 'h022);
        man_read();
        chk(!data_valid, "R12 queue empty after reads", int'(data_valid), 0);

        // R10 overrun
        uart_send(9'h0A1, 0, 1'b1);
        uart_send(9'h0B2, 0, 1'b1);
        chk(!csr_rdata[1], "R10 no overrun at two words", int'(csr_rdata[1]), 0);
        uart_send(9'h0C3, 0, 1'b1);
        chk(csr_rdata[1], "R10 overrun set", int'(csr_rdata[1]), 1);
        chk(data_out == 8'hA1, "R10 head kept", int'(data_out), 'hA1);
        man_read();
        chk(data_out == 8'hB2, "R10 third word discarded", int'(data_out), 'hB2);
        man_read();
        uart_send(9'h0D4, 0, 1'b1);
        chk(!data_valid, "R10 halted while overrun", int'(data_valid), 0);
        // R11 clearing rule
        wr(8'hD0);
        chk(csr_rdata[1], "R11 overrun kept with cren=1", int'(csr_rdata[1]), 1);
        wr(8'h80);
        chk(!csr_rdata[1], "R11 overrun cleared by cren=0", int'(csr_rdata[1]), 0);
        auto_rd = 1'b1;
        wr(8'h90);
        exp_q.push_back({2'b00, 8'hE5}); uart_send(9'h0E5, 0, 1'b1);
        drain("R11 reception resumes");

        // R8 synchronous single-shot
        wr(8'h00);
        sync_mode = 1'b1;
        rx_in = 1'b0;
        exp_q.push_back({2'b00, 8'h6A});
        wr(8'hA0);
        sync_bits(18'h0006A, 8);
        drain("R8 one sync word");
        repeat (50) @(posedge clk); #1;
        chk(!csr_rdata[5], "R8 sren auto-cleared", int'(csr_rdata[5]), 0);
        chk(!sclk_out, "R8 clock stopped low", int'(sclk_out), 0);
        chk(!data_valid, "R8 exactly one word", int'(data_valid), 0);

        // R9 continuous overrides single-shot
        rx_in = 1'b0;
        exp_q.push_back({2'b00, 8'h96});
        exp_q.push_back({2'b00, 8'h0F});
        wr(8'hB0);
        sync_bits({2'b00, 8'h0F, 8'h96}, 16);
        chk(csr_rdata[5], "R9 sren not cleared under cren", int'(csr_rdata[5]), 1);
        wr(8'h80);
        drain("R9 two sync words");
        repeat (20) @(posedge clk); #1;
        chk(!sclk_out, "R9 clock stops after cren cleared", int'(sclk_out), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule